// File: doc/BRIEF.md
# Interrupt Priority Arbiter

The block collects interrupt requests from a set of devices. Each device presents a request line, a per-device enable bit and a 3-bit urgency level from 0 (least urgent) to 7 (most urgent). Among the enabled, requesting devices it picks the one with the highest level. When several devices share that level, the lowest device index wins. The winning level is then compared with the level of the program the processor is running. A single interrupt line is raised only when the winner is strictly more urgent, so an equal or less urgent device never preempts the running program.

The outputs are registered. Once the interrupt line is raised, it holds, together with the winning level and device index, until the processor acknowledges. The processor checks the line at instruction boundaries, so a stable value is needed until it reacts. After an acknowledge the outputs are recomputed from the inputs present at the next clock edge.

Top module: `irq_prio_arb`

## Requirements
- R1: A device whose request bit is 0, or whose enable bit in `en_i` is 0, never appears as the winner.
- R2: Among enabled, requesting devices, the winner is the one with the largest level. Device i's level is `lvl_i[3*i+2:3*i]`.
- R3: When several such devices share the largest level, the device with the smallest index wins.
- R4: `irq_o` is raised only if the winning level is strictly greater than `cur_lvl_i`. An equal or lower winning level leaves `irq_o` at 0.
- R5: While `irq_o` is 0, the outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R6: While `irq_o` is 1 and `ack_i` is 0, `irq_o`, `win_lvl_o` and `win_idx_o` keep their values, even if the inputs change.
- R7: When `ack_i` is 1 at a clock edge, all outputs are reloaded at that edge from the current inputs.
- R8: With no enabled request, an update sets `irq_o`, `win_lvl_o` and `win_idx_o` to 0.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Request line per device |
| en_i | input | N_DEV | Enable per device, 1 = request may win |
| lvl_i | input | 3*N_DEV | Packed levels, device i in bits [3i+2:3i] |
| cur_lvl_i | input | 3 | Level of the running program |
| ack_i | input | 1 | Processor acknowledge, forces reload |
| irq_o | output | 1 | Interrupt request to the processor |
| win_lvl_o | output | 3 | Level of the selected device |
| win_idx_o | output | IDX_W | Index of the selected device |

## Verification
A wrong comparison or a broken selection chain shows at the ports one cycle after the inputs that expose it. It appears as a wrong index, a wrong level, or an interrupt raised for an equal level. A hold register that fails to freeze shows as an index or level that changes while the interrupt line is high. A missed reload after an acknowledge shows as stale outputs on the cycle that follows. Random inputs with frequent level ties and random acknowledges reach these cases within a few cycles of each other. Directed cases pin the preemption boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_prio_chain.sv
module irq_prio_chain
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_DEV = 8,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_DEV-1:0]       act_i,
  input  logic [N_DEV*LVL_W-1:0] lvl_i,
  output logic                   vld_o,
  output lvl_t                   lvl_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [N_DEV:0]   c_vld;
  lvl_t             c_lvl [N_DEV+1];
  logic [IDX_W-1:0] c_idx [N_DEV+1];

  assign c_vld[0] = 1'b0;
  assign c_lvl[0] = '0;
  assign c_idx[0] = '0;

  // strict compare keeps the earlier (lower) index on ties
  for (genvar g = 0; g < N_DEV; g++) begin : g_stage
    lvl_t d_lvl;
    logic take;
    assign d_lvl        = lvl_i[g*LVL_W +: LVL_W];
    assign take         = act_i[g] && (!c_vld[g] || (d_lvl > c_lvl[g]));
    assign c_vld[g+1]   = c_vld[g] | act_i[g];
    assign c_lvl[g+1]   = take ? d_lvl : c_lvl[g];
    assign c_idx[g+1]   = take ? IDX_W'(g) : c_idx[g];
  end

  assign vld_o = c_vld[N_DEV];
  assign lvl_o = c_lvl[N_DEV];
  assign idx_o = c_idx[N_DEV];

  AST_WIN_IS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> act_i[idx_o]); // R1
  AST_WIN_LVL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (lvl_i[idx_o*LVL_W +: LVL_W] == lvl_o)); // R2
endmodule

// File: rtl/irq_gate_reg.sv
module irq_gate_reg
  import irq_arb_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  lvl_t             lvl_i,
  input  logic [IDX_W-1:0] idx_i,
  input  lvl_t             cur_lvl_i,
  input  logic             ack_i,
  output logic             irq_o,
  output lvl_t             lvl_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             irq_q;
  lvl_t             lvl_q;
  logic [IDX_W-1:0] idx_q;
  logic             upd;

  assign upd = !irq_q || ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      lvl_q <= '0;
      idx_q <= '0;
    end else if (upd) begin
      irq_q <= vld_i && (lvl_i > cur_lvl_i);
      lvl_q <= vld_i ? lvl_i : '0;
      idx_q <= vld_i ? idx_i : '0;
    end
  end

  assign irq_o = irq_q;
  assign lvl_o = lvl_q;
  assign idx_o = idx_q;

  AST_RAISE_ABOVE_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (lvl_o > $past(cur_lvl_i))); // R4
  AST_IRQ_NONZERO_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (lvl_o != '0)); // R4
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(lvl_o) && $stable(idx_o))); // R6
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_DEV = 8,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_DEV-1:0]       req_i,
  input  logic [N_DEV-1:0]       en_i,
  input  logic [N_DEV*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]       cur_lvl_i,
  input  logic                   ack_i,
  output logic                   irq_o,
  output logic [LVL_W-1:0]       win_lvl_o,
  output logic [IDX_W-1:0]       win_idx_o
);
  logic [N_DEV-1:0] act;
  logic             sel_vld;
  lvl_t             sel_lvl;
  logic [IDX_W-1:0] sel_idx;

  assign act = req_i & en_i;

  irq_prio_chain #(.N_DEV(N_DEV)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .lvl_i  (lvl_i),
    .vld_o  (sel_vld),
    .lvl_o  (sel_lvl),
    .idx_o  (sel_idx)
  );

  irq_gate_reg #(.IDX_W(IDX_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (sel_vld),
    .lvl_i     (sel_lvl),
    .idx_i     (sel_idx),
    .cur_lvl_i (cur_lvl_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .lvl_o     (win_lvl_o),
    .idx_o     (win_idx_o)
  );

  AST_NO_REQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && (act == '0)) |=> (!irq_o && (win_lvl_o == '0) && (win_idx_o == '0))); // R8
endmodule

// File: tb/irq_prio_arb_test.sv
module irq_prio_arb_test;
  localparam int unsigned N = 8;
  localparam int unsigned IW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, en = '0;
  logic [3*N-1:0] lvl = '0;
  logic [2:0]    cur = '0;
  logic          ack = 1'b0;
  logic          irq;
  logic [2:0]    wlvl;
  logic [IW-1:0] widx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic          m_irq;
  logic [2:0]    m_lvl;
  logic [IW-1:0] m_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arb #(.N_DEV(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en), .lvl_i(lvl),
    .cur_lvl_i(cur), .ack_i(ack), .irq_o(irq), .win_lvl_o(wlvl), .win_idx_o(widx)
  );

  function automatic logic [7:0] best(input logic [N-1:0] r, input logic [N-1:0] e,
                                      input logic [3*N-1:0] l);
    // returns {vld, lvl[2:0], idx[3:0]}
    logic v; logic [2:0] bl; logic [3:0] bi;
    v = 0; bl = 0; bi = 0;
    for (int i = 0; i < N; i++) begin
      if (r[i] && e[i] && (!v || l[3*i +: 3] > bl)) begin
        v = 1; bl = l[3*i +: 3]; bi = 4'(i);
      end
    end
    return {v, bl, bi};
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (irq !== m_irq || wlvl !== m_lvl || widx !== m_idx) begin
      n_fail++;
      $display("FAIL %s: got irq=%0b lvl=%0d idx=%0d, exp irq=%0b lvl=%0d idx=%0d",
               tag, irq, wlvl, widx, m_irq, m_lvl, m_idx);
    end
  endtask

  // advance one edge, update reference model from pre-edge inputs, sample after
  task automatic step(input string tag);
    logic [7:0] b;
    logic upd;
    b = best(req, en, lvl);
    upd = !m_irq || ack;
    @(posedge clk);
    if (upd) begin
      m_irq = b[7] && (b[6:4] > cur);
      m_lvl = b[7] ? b[6:4] : 3'd0;
      m_idx = b[7] ? IW'(b[3:0]) : '0;
    end
    #1;
    check(tag);
  endtask

  function automatic logic [3*N-1:0] all_lvl(input logic [2:0] v);
    logic [3*N-1:0] r;
    for (int i = 0; i < N; i++) r[3*i +: 3] = v;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_irq = 0; m_lvl = 0; m_idx = 0;
    #3;
    check("R9 reset");
    repeat (2) @(posedge clk);
    #1;
    check("R9 reset held");
    rst_n = 1'b1;

    // R8: no request
    en = '1;
    step("R8 idle");

    // R4: level 6 device preempts level 0 program
    cur = 3'd0; lvl = '0; lvl[3*2 +: 3] = 3'd6; req = 8'b0000_0100;
    step("R4 6 over 0");
    ack = 1; step("R7 ack reload"); ack = 0;

    // R4: level 0 device cannot preempt level 6 program
    cur = 3'd6; lvl = '0; req = 8'b0000_0001;
    ack = 1; step("R4 0 under 6"); ack = 0;
    // R4: equal level does not preempt
    lvl[3*5 +: 3] = 3'd6; req = 8'b0010_0000;
    step("R4 equal level");

    // R3: tie goes to lowest index
    cur = 3'd0; lvl = all_lvl(3'd4); req = 8'b1010_1000;
    step("R3 tie lowest idx");

    // R6: hold while irq high without ack
    lvl[3*7 +: 3] = 3'd7; req = 8'b1111_1111;
    step("R6 hold");
    step("R6 hold again");

    // R7 then R2: reload to the level-7 device
    ack = 1; step("R7 ack picks R2 max"); ack = 0;

    // R1: masked device never wins
    ack = 1; lvl = '0; lvl[3*1 +: 3] = 3'd7; lvl[3*3 +: 3] = 3'd2;
    req = 8'b0000_1010; en = 8'b1111_1101;
    step("R1 masked"); ack = 0;
    ack = 1; en = 8'b0000_0000; step("R8 all masked"); ack = 0;
    en = '1;

    // random mix
    for (int k = 0; k < 3000; k++) begin
      string tag;
      req = 8'($urandom) & 8'($urandom);
      en  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
      for (int i = 0; i < N; i++) lvl[3*i +: 3] = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0) lvl = all_lvl(3'($urandom_range(0, 7)));
      cur = 3'($urandom_range(0, 7));
      ack = ($urandom_range(0, 3) == 0);
      if (m_irq && !ack) tag = "R6 rand";
      else if (ack) tag = "R7 rand";
      else tag = "R5 rand R2 R3";
      step(tag);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule